// File: doc/BRIEF.md
# PCI Bus Reset Sequencer

This block brings an external PCI bus out of reset in a fixed order once the host side is enabled. A single-cycle start pulse launches the sequence: the reset and clock output drivers are switched on with the bus clock stopped and bus reset asserted. The bus clock is then started. Reset is held for a minimum time measured from clock start, then released. The arbiter is switched to internal mode, and after a short wait and a much longer settling period a ready output rises. Configuration accesses may be issued only once ready is high.

Every wait is a cycle count derived from the clock frequency parameter (in MHz) times a duration in microseconds, so the same RTL serves any system clock. Once started, the sequence cannot be restarted or disturbed by further start pulses. Ready stays high until the synchronous reset, which returns every output to its driver-disabled, inactive state.

Top module: `pci_bus_bringup`

## Requirements
- R1: While `rst` is high, and in idle after it, all six outputs are 0.
- R2: A start pulse seen in idle makes `rst_oe`=1 and `clk_oe`=1 with `clk_en`=0 and `rst_n`=0 from the next cycle, for exactly one cycle.
- R3: `clk_en` then rises while `rst_n` stays 0 for exactly CLK_MHZ*RST_HOLD_US cycles, the minimum reset hold after clock start.
- R4: `rst_n` then rises alone; `arb_internal` rises exactly one cycle later and never while `rst_n` is 0.
- R5: `ready` rises exactly CLK_MHZ*(ARB_WAIT_US+SETTLE_US) cycles after `arb_internal` rises, with all other outputs high.
- R6: Once high, `ready` and the other outputs stay high until `rst`; start pulses in this state have no effect.
- R7: Start pulses while the sequence runs change none of the phase lengths above.
- R8: A `rst` in the middle of the sequence returns all outputs to 0 in the next cycle, and the block stays idle until a new start.
- R9: `clk_en` is never 1 unless both `clk_oe` and `rst_oe` are 1.

Output code used by the bench, as {ready, arb_internal, rst_n, clk_en, clk_oe, rst_oe}: 0x03 drivers on, 0x07 clock running, 0x0F reset released, 0x1F arbiter internal and waiting, 0x3F ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches the bring-up from idle |
| rst_oe | output | 1 | Enable for the bus reset output driver |
| clk_oe | output | 1 | Enable for the bus clock output driver |
| clk_en | output | 1 | Bus clock running |
| rst_n | output | 1 | Bus reset level, 0 = asserted |
| arb_internal | output | 1 | Select internal bus arbiter |
| ready | output | 1 | Configuration accesses permitted |

## Verification
The assertions watch every cycle for ordering rules: the clock never runs without both drivers, the arbiter is never internal under reset, reset is never released before the hold count, ready never rises before the full wait and never falls without reset. Exact phase lengths, the ignoring of start pulses during a run or after ready, and recovery from a reset at a random point are shown only by the bench scenarios, which time each output code against counts computed from the parameters.

// File: rtl/pci_bringup_pkg.sv
package pci_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRV     = 3'd1,
    ST_CLKRUN  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_ARB     = 3'd4,
    ST_SETTLE  = 3'd5,
    ST_READY   = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic ready;
    logic arb_internal;
    logic rst_n;
    logic clk_en;
    logic clk_oe;
    logic rst_oe;
  } bus_ctl_t;

  function automatic bus_ctl_t decode_ctl(seq_state_e s);
    bus_ctl_t c;
    c = '0;
    case (s)
      ST_DRV:     c = '{ready:1'b0, arb_internal:1'b0, rst_n:1'b0, clk_en:1'b0, clk_oe:1'b1, rst_oe:1'b1};
      ST_CLKRUN:  c = '{ready:1'b0, arb_internal:1'b0, rst_n:1'b0, clk_en:1'b1, clk_oe:1'b1, rst_oe:1'b1};
      ST_RELEASE: c = '{ready:1'b0, arb_internal:1'b0, rst_n:1'b1, clk_en:1'b1, clk_oe:1'b1, rst_oe:1'b1};
      ST_ARB,
      ST_SETTLE:  c = '{ready:1'b0, arb_internal:1'b1, rst_n:1'b1, clk_en:1'b1, clk_oe:1'b1, rst_oe:1'b1};
      ST_READY:   c = '{ready:1'b1, arb_internal:1'b1, rst_n:1'b1, clk_en:1'b1, clk_oe:1'b1, rst_oe:1'b1};
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pcib_timer.sv
module pcib_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pcib_fsm.sv
module pcib_fsm
  import pci_bringup_pkg::*;
#(
  parameter int TW         = 8,
  parameter int HOLD_CYC   = 1,
  parameter int ARB_CYC    = 1,
  parameter int SETTLE_CYC = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          tmr_expired,
  output seq_state_e    state_nxt,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val
);
  seq_state_e state_q;

  always_comb begin
    state_nxt = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    case (state_q)
      ST_IDLE:    if (start) state_nxt = ST_DRV;
      ST_DRV: begin
        state_nxt = ST_CLKRUN;
        tmr_load  = 1'b1;
        tmr_val   = TW'(HOLD_CYC - 1);
      end
      ST_CLKRUN:  if (tmr_expired) state_nxt = ST_RELEASE;
      ST_RELEASE: begin
        state_nxt = ST_ARB;
        tmr_load  = 1'b1;
        tmr_val   = TW'(ARB_CYC - 1);
      end
      ST_ARB: begin
        if (tmr_expired) begin
          state_nxt = ST_SETTLE;
          tmr_load  = 1'b1;
          tmr_val   = TW'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE:  if (tmr_expired) state_nxt = ST_READY;
      ST_READY:   state_nxt = ST_READY;
      default:    state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end
endmodule

// File: rtl/pcib_outreg.sv
module pcib_outreg
  import pci_bringup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_nxt,
  output bus_ctl_t   ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= decode_ctl(state_nxt);
  end
endmodule

// File: rtl/pci_bus_bringup.sv
module pci_bus_bringup
  import pci_bringup_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int RST_HOLD_US = 150,
  parameter int ARB_WAIT_US = 1,
  parameter int SETTLE_US   = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rst_oe,
  output logic clk_oe,
  output logic clk_en,
  output logic rst_n,
  output logic arb_internal,
  output logic ready
);
  localparam int HOLD_RAW   = CLK_MHZ * RST_HOLD_US;
  localparam int ARB_RAW    = CLK_MHZ * ARB_WAIT_US;
  localparam int SETTLE_RAW = CLK_MHZ * SETTLE_US;
  localparam int HOLD_CYC   = (HOLD_RAW   < 1) ? 1 : HOLD_RAW;
  localparam int ARB_CYC    = (ARB_RAW    < 1) ? 1 : ARB_RAW;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int MAX_CYC    = (HOLD_CYC > SETTLE_CYC)
                              ? ((HOLD_CYC > ARB_CYC) ? HOLD_CYC : ARB_CYC)
                              : ((SETTLE_CYC > ARB_CYC) ? SETTLE_CYC : ARB_CYC);
  localparam int TW         = $clog2(MAX_CYC + 1);

  seq_state_e    state_nxt;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  bus_ctl_t      ctl_q;

  pcib_fsm #(
    .TW(TW), .HOLD_CYC(HOLD_CYC), .ARB_CYC(ARB_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .tmr_expired(tmr_expired),
    .state_nxt(state_nxt), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  pcib_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  pcib_outreg u_out (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .ctl_q(ctl_q)
  );

  assign rst_oe       = ctl_q.rst_oe;
  assign clk_oe       = ctl_q.clk_oe;
  assign clk_en       = ctl_q.clk_en;
  assign rst_n        = ctl_q.rst_n;
  assign arb_internal = ctl_q.arb_internal;
  assign ready        = ctl_q.ready;
endmodule

// File: rtl/pcib_checker.sv
module pcib_checker #(
  parameter int HOLD_CYC = 1,
  parameter int WAIT_CYC = 1
) (
  input logic clk,
  input logic rst,
  input logic rst_oe,
  input logic clk_oe,
  input logic clk_en,
  input logic rst_n,
  input logic arb_internal,
  input logic ready
);
  logic [31:0] hold_cnt;
  logic [31:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      wait_cnt <= '0;
    end else begin
      hold_cnt <= (clk_en && !rst_n) ? hold_cnt + 1 : '0;
      wait_cnt <= (arb_internal && !ready) ? wait_cnt + 1 : '0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !(rst_oe || clk_oe || clk_en || rst_n || arb_internal || ready)); // R1
  AST_DRV_BEFORE_CLK: assert property (@(posedge clk) disable iff (rst) $rose(clk_oe) |-> (rst_oe && !clk_en && !rst_n)); // R2
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst) $rose(rst_n) |-> (hold_cnt >= 32'(HOLD_CYC))); // R3
  AST_ARB_AFTER_REL: assert property (@(posedge clk) disable iff (rst) arb_internal |-> rst_n); // R4
  AST_READY_WAIT: assert property (@(posedge clk) disable iff (rst) $rose(ready) |-> (wait_cnt >= 32'(WAIT_CYC) && clk_en && rst_n)); // R5
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst) ready |=> ready); // R6
  AST_CLK_WITH_DRV: assert property (@(posedge clk) disable iff (rst) clk_en |-> (clk_oe && rst_oe)); // R9
endmodule

bind pci_bus_bringup pcib_checker #(
  .HOLD_CYC(HOLD_CYC), .WAIT_CYC(ARB_CYC + SETTLE_CYC)
) u_chk (
  .clk(clk), .rst(rst), .rst_oe(rst_oe), .clk_oe(clk_oe), .clk_en(clk_en),
  .rst_n(rst_n), .arb_internal(arb_internal), .ready(ready)
);

// File: tb/pci_bus_bringup_bench.sv
module pci_bus_bringup_bench;
  localparam int MHZ     = 2;
  localparam int HOLD_US = 150;
  localparam int ARB_US  = 1;
  localparam int SET_US  = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic rst_oe, clk_oe, clk_en, rst_n, arb_internal, ready;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pci_bus_bringup #(
    .CLK_MHZ(MHZ), .RST_HOLD_US(HOLD_US), .ARB_WAIT_US(ARB_US), .SETTLE_US(SET_US)
  ) u_pci_bus_bringup (
    .clk(clk), .rst(rst), .start(start), .rst_oe(rst_oe), .clk_oe(clk_oe),
    .clk_en(clk_en), .rst_n(rst_n), .arb_internal(arb_internal), .ready(ready)
  );

  function automatic int exp_hold();
    return MHZ * HOLD_US;
  endfunction

  function automatic int exp_wait();
    return MHZ * (ARB_US + SET_US);
  endfunction

  function automatic logic [5:0] out_code();
    return {ready, arb_internal, rst_n, clk_en, clk_oe, rst_oe};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic measure(input bit noise, output logic [5:0] c, output int len);
    c = out_code();
    len = 0;
    while (out_code() == c && len < 10000) begin
      len++;
      start = (noise && ($urandom % 40 == 0));
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic pulse_start();
    repeat ($urandom % 5) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_full(input bit noise);
    logic [5:0] c;
    int len;
    int bad;
    pulse_start();
    measure(noise, c, len);
    chk(c == 6'h03, "R2 drivers-on code", c, 6'h03);
    chk(len == 1, "R2 drivers-on length", len, 1);
    measure(noise, c, len);
    chk(c == 6'h07, "R3 clock-run code", c, 6'h07);
    chk(len == exp_hold(), noise ? "R7 hold length" : "R3 hold length", len, exp_hold());
    measure(noise, c, len);
    chk(c == 6'h0F, "R4 release code", c, 6'h0F);
    chk(len == 1, "R4 release length", len, 1);
    measure(noise, c, len);
    chk(c == 6'h1F, "R5 arbiter code", c, 6'h1F);
    chk(len == exp_wait(), noise ? "R7 wait length" : "R5 wait length", len, exp_wait());
    chk(out_code() == 6'h3F, "R5 ready code", out_code(), 6'h3F);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      start = ($urandom % 3 == 0);
      @(negedge clk);
      if (out_code() != 6'h3F) bad++;
    end
    start = 1'b0;
    chk(bad == 0, "R6 ready held under start pulses", bad, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_code() == 6'h00, "R1 reset after ready", out_code(), 0);
  endtask

  task automatic run_abort();
    int k;
    int bad;
    k = 1 + ($urandom % (exp_hold() + exp_wait() + 2));
    pulse_start();
    repeat (k) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(out_code() == 6'h00, "R8 mid-sequence reset", out_code(), 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_code() != 6'h00) bad++;
    end
    chk(bad == 0, "R8 stays idle after reset", bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(out_code() == 6'h00, "R1 outputs during reset", out_code(), 0);
    rst = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (out_code() != 6'h00) bad++;
      if (clk_en && !(clk_oe && rst_oe)) bad++;
    end
    chk(bad == 0, "R1 idle without start, R9 no clock without drivers", bad, 0);
    run_full(1'b0);
    run_abort();
    run_full(1'b1);
    for (int r = 0; r < 3; r++) run_abort();
    run_full(1'b1);
    rst = 1'b1;
    start = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    start = 1'b0;
    @(negedge clk);
    chk(out_code() == 6'h00, "R1 start during reset has no effect", out_code(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule